// File: doc/BRIEF.md
# Q-Channel Quiescence Request Distributor

This block sits between one power controller and a set of device channels that each speak the Q-Channel quiescence handshake. A single controller request is fanned out to every channel. The channel replies are merged back into one controller reply. The controller sees an accept only when every channel has accepted. It sees a deny as soon as the full set of replies contains at least one deny.

The controller request input can be treated as asynchronous. The per-channel accept and deny inputs can also be treated as asynchronous. A separate parameter for each side places a two-flop synchroniser in that path. Every output of the handshake is registered on the block clock. The exception is the merged activity hint, which is a pure OR of the channel activity inputs.

A clock-request output tells an external clock controller when the block is part-way through a handshake and needs its clock. A test clock-enable input forces that request high during scan shift.

Top module: `qch_fanout`

## Requirements
- R1: During and after reset, with no stimulus applied, all channel requests (`dev_req_n_o`) are 1, `ctrl_accept_n_o` is 1, `ctrl_deny_o` is 0 and `clk_req_o` is 0.
- R2: A fall of `ctrl_req_n_i` drives every bit of `dev_req_n_o` low in the same cycle. This happens L clock edges after the input change, where L = 3 when CTRL_SYNC = 1 and L = 1 when CTRL_SYNC = 0. All channel requests always carry the same value.
- R3: Suppose every channel shows `dev_accept_n_i` = 0 and none shows `dev_deny_i` = 1. Then `ctrl_accept_n_o` falls L' edges after the last channel responds (L' = 3 when DEV_SYNC = 1, otherwise 1), and not before.
- R4: During entry, the block waits until every channel has responded with either accept low or deny high. If any channel denied, `ctrl_deny_o` rises L' edges after the last response and `ctrl_accept_n_o` stays 1. Neither output changes while any channel has not yet responded.
- R5: From either the stopped state or the denied state, a rise of `ctrl_req_n_i` drives all of `dev_req_n_o` high L edges later.
- R6: During exit, `ctrl_accept_n_o` returns to 1 and `ctrl_deny_o` returns to 0 only once every channel shows accept high and deny low. This happens L' edges after the last channel releases.
- R7: `ctrl_active_o` is the combinational OR of all bits of `dev_active_i`.
- R8: `clk_req_o` is 1 while entering, while exiting and while denied. It is 0 in the idle run state and in the idle stopped state (unless R9 applies).
- R9: `test_cg_en_i` = 1 forces `clk_req_o` to 1 combinationally.
- R10: `ctrl_accept_n_o` = 0 and `ctrl_deny_o` = 1 never occur together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| test_cg_en_i | input | 1 | Test clock-enable override |
| clk_req_o | output | 1 | Block needs its clock |
| ctrl_req_n_i | input | 1 | Controller quiescence request, active low |
| ctrl_accept_n_o | output | 1 | Merged accept, active low |
| ctrl_deny_o | output | 1 | Merged deny |
| ctrl_active_o | output | 1 | Any channel active |
| dev_req_n_o | output | NUM_CH | Per-channel request, active low |
| dev_accept_n_i | input | NUM_CH | Per-channel accept, active low |
| dev_deny_i | input | NUM_CH | Per-channel deny |
| dev_active_i | input | NUM_CH | Per-channel activity hint |

## Verification
The hardest situation to reach is a mixed reply, in which some channels accept and others deny, arriving in different cycles. The merged reply must hold off until the slowest channel has answered. On exit, the accepted and the denied channels must be released on their own schedules. The bench gives each channel a random response delay and a random deny choice from a fixed seed. It checks that the controller outputs stay unchanged in every cycle before the last response has passed the synchroniser, and that they change exactly on the expected edge. Directed rounds add the all-accept case, the all-deny case and the single-deny case.

// File: rtl/qch_pkg.sv
package qch_pkg;
  typedef enum logic [2:0] {
    Q_RUN     = 3'd0,
    Q_ENTER   = 3'd1,
    Q_STOPPED = 3'd2,
    Q_DENIED  = 3'd3,
    Q_EXIT    = 3'd4
  } q_state_e;
endpackage

// File: rtl/qch_sync.sv
module qch_sync #(
  parameter int          W       = 1,
  parameter bit          EN      = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (EN) begin : g_ff2
      logic [W-1:0] s1_q, s2_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s1_q <= RST_VAL;
          s2_q <= RST_VAL;
        end else begin
          s1_q <= d_i;
          s2_q <= s1_q;
        end
      end
      assign q_o = s2_q;
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/qch_fsm.sv
module qch_fsm
  import qch_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_n_i,
  input  logic [NUM_CH-1:0] acc_n_i,
  input  logic [NUM_CH-1:0] deny_i,
  output logic [NUM_CH-1:0] dev_req_n_o,
  output logic              accept_n_o,
  output logic              deny_o,
  output logic              busy_o
);
  q_state_e state_q, state_d;
  logic req_q, req_d, acc_n_q, acc_n_d, deny_q, deny_d;
  logic [NUM_CH-1:0] responded, cleared;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign responded[i] = !acc_n_i[i] || deny_i[i];
    assign cleared[i]   = acc_n_i[i] && !deny_i[i];
    assign dev_req_n_o[i] = req_q;
  end

  logic all_resp, any_deny, all_clear;
  assign all_resp  = &responded;
  assign any_deny  = |deny_i;
  assign all_clear = &cleared;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    acc_n_d = acc_n_q;
    deny_d  = deny_q;
    unique case (state_q)
      Q_RUN: if (!req_n_i) begin
        state_d = Q_ENTER;
        req_d   = 1'b0;
      end
      Q_ENTER: if (all_resp) begin
        if (any_deny) begin
          state_d = Q_DENIED;
          deny_d  = 1'b1;
        end else begin
          state_d = Q_STOPPED;
          acc_n_d = 1'b0;
        end
      end
      Q_STOPPED, Q_DENIED: if (req_n_i) begin
        state_d = Q_EXIT;
        req_d   = 1'b1;
      end
      Q_EXIT: if (all_clear) begin
        state_d = Q_RUN;
        acc_n_d = 1'b1;
        deny_d  = 1'b0;
      end
      default: state_d = Q_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= Q_RUN;
      req_q   <= 1'b1;
      acc_n_q <= 1'b1;
      deny_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      acc_n_q <= acc_n_d;
      deny_q  <= deny_d;
    end
  end

  assign accept_n_o = acc_n_q;
  assign deny_o     = deny_q;
  assign busy_o     = (state_q != Q_RUN) && (state_q != Q_STOPPED);

  // R2
  dev_req_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_req_n_o[0]) |-> $past(!req_n_i));
  // R3
  accept_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(accept_n_o) |-> $past(all_resp && !any_deny));
  // R4
  deny_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deny_o) |-> $past(all_resp && any_deny));
  // R6
  exit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(accept_n_o) || $fell(deny_o)) |-> $past(all_clear));
  // R10
  acc_deny_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!accept_n_o && deny_o));
endmodule

// File: rtl/qch_fanout.sv
module qch_fanout #(
  parameter int NUM_CH    = 4,
  parameter bit CTRL_SYNC = 1'b1,
  parameter bit DEV_SYNC  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_cg_en_i,
  output logic              clk_req_o,
  input  logic              ctrl_req_n_i,
  output logic              ctrl_accept_n_o,
  output logic              ctrl_deny_o,
  output logic              ctrl_active_o,
  output logic [NUM_CH-1:0] dev_req_n_o,
  input  logic [NUM_CH-1:0] dev_accept_n_i,
  input  logic [NUM_CH-1:0] dev_deny_i,
  input  logic [NUM_CH-1:0] dev_active_i
);
  localparam int RW = 2 * NUM_CH;

  logic              req_n_s;
  logic [RW-1:0]     resp_s;
  logic              busy;

  qch_sync #(.W(1), .EN(CTRL_SYNC), .RST_VAL(1'b1)) u_ctrl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctrl_req_n_i), .q_o(req_n_s)
  );

  qch_sync #(.W(RW), .EN(DEV_SYNC), .RST_VAL({{NUM_CH{1'b0}}, {NUM_CH{1'b1}}})) u_dev_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({dev_deny_i, dev_accept_n_i}), .q_o(resp_s)
  );

  qch_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_n_i(req_n_s),
    .acc_n_i(resp_s[NUM_CH-1:0]),
    .deny_i(resp_s[RW-1:NUM_CH]),
    .dev_req_n_o(dev_req_n_o),
    .accept_n_o(ctrl_accept_n_o),
    .deny_o(ctrl_deny_o),
    .busy_o(busy)
  );

  assign clk_req_o     = busy || test_cg_en_i;
  assign ctrl_active_o = |dev_active_i;

  // R9
  test_clk_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_cg_en_i |-> clk_req_o);
  // R2
  dev_req_uniform_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_req_n_o == '0) || (dev_req_n_o == '1));
endmodule

// File: tb/qch_fanout_test.sv
module qch_fanout_test;
  localparam int N     = 4;
  localparam bit CSYNC = 1'b1;
  localparam bit DSYNC = 1'b1;
  localparam int LC    = CSYNC ? 3 : 1;
  localparam int LD    = DSYNC ? 3 : 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, test_cg_en_i = 1'b0;
  logic ctrl_req_n_i = 1'b1;
  logic [N-1:0] dev_accept_n_i = '1, dev_deny_i = '0, dev_active_i = '0;
  logic clk_req_o, ctrl_accept_n_o, ctrl_deny_o, ctrl_active_o;
  logic [N-1:0] dev_req_n_o;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  qch_fanout #(.NUM_CH(N), .CTRL_SYNC(CSYNC), .DEV_SYNC(DSYNC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .test_cg_en_i(test_cg_en_i),
    .clk_req_o(clk_req_o), .ctrl_req_n_i(ctrl_req_n_i),
    .ctrl_accept_n_o(ctrl_accept_n_o), .ctrl_deny_o(ctrl_deny_o),
    .ctrl_active_o(ctrl_active_o), .dev_req_n_o(dev_req_n_o),
    .dev_accept_n_i(dev_accept_n_i), .dev_deny_i(dev_deny_i),
    .dev_active_i(dev_active_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] ctrl_pair(input logic acc_n, input logic dn);
    return {30'd0, acc_n, dn};
  endfunction

  function automatic logic [31:0] exp_active(input logic [N-1:0] a);
    return {31'd0, |a};
  endfunction

  task automatic round(input logic [N-1:0] dmask);
    int d[N];
    int maxd;
    logic [31:0] exp_rep;
    // entry
    step();
    ctrl_req_n_i = 1'b0;
    repeat (LC - 1) begin step(); chk("R2 early", {28'd0, dev_req_n_o}, {28'd0, {N{1'b1}}}); end
    step();
    chk("R2 fan-out", {28'd0, dev_req_n_o}, 32'd0);
    chk("R8 entering", {31'd0, clk_req_o}, 32'd1);
    maxd = 0;
    for (int i = 0; i < N; i++) begin
      d[i] = $urandom_range(0, 5);
      if (d[i] > maxd) maxd = d[i];
    end
    for (int t = 0; t <= maxd; t++) begin
      for (int i = 0; i < N; i++)
        if (d[i] == t) begin
          if (dmask[i]) dev_deny_i[i] = 1'b1;
          else dev_accept_n_i[i] = 1'b0;
        end
      if (t != maxd) begin
        step();
        chk("R4 waits for all", ctrl_pair(ctrl_accept_n_o, ctrl_deny_o), ctrl_pair(1'b1, 1'b0));
      end
    end
    repeat (LD - 1) begin
      step();
      chk("R3 no early reply", ctrl_pair(ctrl_accept_n_o, ctrl_deny_o), ctrl_pair(1'b1, 1'b0));
    end
    step();
    exp_rep = (dmask != '0) ? ctrl_pair(1'b1, 1'b1) : ctrl_pair(1'b0, 1'b0);
    chk((dmask != '0) ? "R4 deny" : "R3 accept", ctrl_pair(ctrl_accept_n_o, ctrl_deny_o), exp_rep);
    chk("R8 after entry", {31'd0, clk_req_o}, {31'd0, dmask != '0});
    chk("R10 exclusive", {31'd0, !ctrl_accept_n_o && ctrl_deny_o}, 32'd0);
    // exit
    ctrl_req_n_i = 1'b1;
    repeat (LC - 1) begin step(); chk("R5 early", {28'd0, dev_req_n_o}, 32'd0); end
    step();
    chk("R5 raise", {28'd0, dev_req_n_o}, {28'd0, {N{1'b1}}});
    chk("R8 exiting", {31'd0, clk_req_o}, 32'd1);
    maxd = 0;
    for (int i = 0; i < N; i++) begin
      d[i] = $urandom_range(0, 5);
      if (d[i] > maxd) maxd = d[i];
    end
    for (int t = 0; t <= maxd; t++) begin
      for (int i = 0; i < N; i++)
        if (d[i] == t) begin
          dev_deny_i[i] = 1'b0;
          dev_accept_n_i[i] = 1'b1;
        end
      if (t != maxd) begin
        step();
        chk("R6 holds", ctrl_pair(ctrl_accept_n_o, ctrl_deny_o), exp_rep);
      end
    end
    repeat (LD - 1) begin
      step();
      chk("R6 no early release", ctrl_pair(ctrl_accept_n_o, ctrl_deny_o), exp_rep);
    end
    step();
    chk("R6 run", ctrl_pair(ctrl_accept_n_o, ctrl_deny_o), ctrl_pair(1'b1, 1'b0));
    chk("R8 run idle", {31'd0, clk_req_o}, 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (2) step();
    chk("R1 reset req", {28'd0, dev_req_n_o}, {28'd0, {N{1'b1}}});
    chk("R1 reset reply", ctrl_pair(ctrl_accept_n_o, ctrl_deny_o), ctrl_pair(1'b1, 1'b0));
    rst_ni = 1'b1;
    repeat (3) step();
    chk("R1 idle", ctrl_pair(ctrl_accept_n_o, ctrl_deny_o), ctrl_pair(1'b1, 1'b0));
    chk("R1 clk_req", {31'd0, clk_req_o}, 32'd0);
    // R9
    test_cg_en_i = 1'b1; #1;
    chk("R9 force", {31'd0, clk_req_o}, 32'd1);
    test_cg_en_i = 1'b0; #1;
    chk("R9 release", {31'd0, clk_req_o}, 32'd0);
    // directed: all accept, all deny, single deny
    round('0);
    round('1);
    round(4'b0100);
    for (int k = 0; k < 30; k++) begin
      logic [N-1:0] m;
      for (int i = 0; i < N; i++) m[i] = ($urandom_range(0, 3) == 0);
      dev_active_i = N'($urandom);
      #1;
      chk("R7 active or", {31'd0, ctrl_active_o}, exp_active(dev_active_i));
      round(m);
    end
    dev_active_i = '0; #1;
    chk("R7 idle", {31'd0, ctrl_active_o}, 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule